// File: doc/BRIEF.md
# Flash Bank Erase/Program Sequencer

This block drives a byte-wide parallel flash part that is controlled through command bytes and a status register. A single start pulse starts one job on one bank. Erase mode wipes the whole bank. Program mode writes every byte of the bank from a local buffer, one byte at a time. The sequencer issues each command on a simple byte bus and polls the part's status register until the operation reports completion. It stops waiting after a bounded number of polls. At the end it returns the part to array-read mode and reads the whole bank back to confirm the result.

Reads on the flash bus return data one cycle after the read strobe. The buffer port is combinational: the sequencer drives an address and the buffer's byte is expected on the same cycle. Outcome flags stay valid from the cycle `done` pulses until the next accepted start.

Top module: `flash_bank_seq`

## Requirements
- R1: After reset `busy`, `done`, `timeout`, `stat_err` and `verify_err` are low, and neither `fl_we` nor `fl_re` is asserted while the block is idle.
- R2: An erase writes command 0x20 to address 0 and then confirm 0xD0 to address 0, with no other write between the two.
- R3: Each poll writes 0x70 to address 0 and then reads address 0. The operation is complete on the first poll whose returned byte has bit 7 set, so an operation that needs N polls produces exactly N 0x70 writes.
- R4: For each program byte, 0x40 is written to that byte's address. Then at least SETUP_DLY idle cycles pass, and then the buffer byte for that address is written to the same address. Addresses run from 0 to the last byte of the bank.
- R5: If POLL_LIMIT polls pass without bit 7 set, `timeout` is set and no further byte is programmed. A completion on exactly the POLL_LIMIT-th poll is not a timeout.
- R6: If a completing status byte has any of bits 5, 4 or 3 set (mask 0x38), `stat_err` is set and no further byte is programmed.
- R7: After the last operation (normal or aborted), 0x50 and then 0xFF are written to address 0 before any read-back.
- R8: After an erase, every byte of the bank is read back once, and `verify_err` is set if any byte is not 0xFF.
- R9: After a program, every byte is read back once and compared with the buffer, and `verify_err` is set on any mismatch. The read-back also runs after an abort.
- R10: `busy` rises the cycle after an accepted start and falls the cycle after a one-cycle `done` pulse. Flags are cleared when a start is accepted and otherwise hold while idle.
- R11: A start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle job request |
| mode | input | 1 | 0 erase, 1 program; sampled with start |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| timeout | output | 1 | Poll limit reached |
| stat_err | output | 1 | Error bits seen in completion status |
| verify_err | output | 1 | Read-back mismatch |
| fl_addr | output | ADDR_W | Flash byte address within the bank |
| fl_wdata | output | 8 | Flash write byte |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read byte, valid the cycle after fl_re |
| buf_addr | output | ADDR_W | Source buffer address |
| buf_data | input | 8 | Source buffer byte for buf_addr |

## Verification
The bench builds the block with ADDR_W=3, POLL_LIMIT=6 and SETUP_DLY=3. An 8-byte bank keeps every program and read-back pass to a few hundred cycles. A limit of six polls lets a stuck part reach timeout quickly, and it also lets a part that completes exactly on the last allowed poll probe the boundary. The three-cycle setup delay is long enough that a missing or short wait shows up as a measured gap in the bench's flash model.

// File: rtl/flash_bank_seq.sv
module flash_bank_seq #(
  parameter int ADDR_W     = 13,
  parameter int POLL_LIMIT = 1000000,
  parameter int SETUP_DLY  = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              stat_err,
  output logic              verify_err,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [7:0]        fl_rdata,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [7:0]        buf_data
);
  localparam logic [ADDR_W-1:0] LAST = '1;
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int DW = (SETUP_DLY > 1) ? $clog2(SETUP_DLY) : 1;
  localparam logic [PW-1:0] PLAST = PW'(POLL_LIMIT - 1);
  localparam logic [DW-1:0] DLAST = DW'((SETUP_DLY > 0) ? SETUP_DLY - 1 : 0);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_DLY, S_OP, S_SCMD, S_SRD, S_SCHK,
    S_CLR, S_RST, S_VRD, S_VCHK, S_FIN
  } st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr;
  logic [PW-1:0]     pcnt;
  logic [DW-1:0]     dcnt;
  logic              pmode;
  logic              at_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      addr       <= '0;
      pcnt       <= '0;
      dcnt       <= '0;
      pmode      <= 1'b0;
      timeout    <= 1'b0;
      stat_err   <= 1'b0;
      verify_err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pmode      <= mode;
          addr       <= '0;
          timeout    <= 1'b0;
          stat_err   <= 1'b0;
          verify_err <= 1'b0;
          st         <= S_CMD;
        end
        S_CMD: begin
          dcnt <= '0;
          st   <= (pmode && SETUP_DLY > 0) ? S_DLY : S_OP;
        end
        S_DLY: begin
          dcnt <= dcnt + 1'b1;
          if (dcnt == DLAST) st <= S_OP;
        end
        S_OP: begin
          pcnt <= '0;
          st   <= S_SCMD;
        end
        S_SCMD: st <= S_SRD;
        S_SRD:  st <= S_SCHK;
        S_SCHK: begin
          if (fl_rdata[7]) begin
            if (|(fl_rdata & 8'h38)) begin
              stat_err <= 1'b1;
              st       <= S_CLR;
            end else if (!pmode || addr == LAST) begin
              st <= S_CLR;
            end else begin
              addr <= addr + 1'b1;
              st   <= S_CMD;
            end
          end else if (pcnt == PLAST) begin
            timeout <= 1'b1;
            st      <= S_CLR;
          end else begin
            pcnt <= pcnt + 1'b1;
            st   <= S_SCMD;
          end
        end
        S_CLR: st <= S_RST;
        S_RST: begin
          addr <= '0;
          st   <= S_VRD;
        end
        S_VRD: st <= S_VCHK;
        S_VCHK: begin
          if (fl_rdata != (pmode ? buf_data : 8'hFF)) verify_err <= 1'b1;
          if (addr == LAST) st <= S_FIN;
          else begin
            addr <= addr + 1'b1;
            st   <= S_VRD;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_FIN);
  assign fl_we    = st inside {S_CMD, S_OP, S_SCMD, S_CLR, S_RST};
  assign fl_re    = st inside {S_SRD, S_VRD};
  assign at_base  = (st inside {S_SCMD, S_SRD, S_CLR, S_RST}) ||
                    (!pmode && (st inside {S_CMD, S_OP}));
  assign fl_addr  = at_base ? '0 : addr;
  assign buf_addr = addr;

  always_comb begin
    case (st)
      S_CMD:   fl_wdata = pmode ? 8'h40 : 8'h20;
      S_OP:    fl_wdata = pmode ? buf_data : 8'hD0;
      S_SCMD:  fl_wdata = 8'h70;
      S_CLR:   fl_wdata = 8'h50;
      S_RST:   fl_wdata = 8'hFF;
      default: fl_wdata = 8'h00;
    endcase
  end
endmodule

module flash_bank_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic timeout,
  input logic stat_err,
  input logic verify_err,
  input logic fl_we,
  input logic fl_re
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fl_we && !fl_re));

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({timeout, stat_err, verify_err}));

  assert_done_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

bind flash_bank_seq flash_bank_seq_chk u_chk (.*);

// File: tb/sim_flash_bank_seq.sv
module sim_flash_bank_seq;
  localparam int AW = 3;
  localparam int NB = 1 << AW;
  localparam int PL = 6;
  localparam int SD = 3;

  // mode, nbusy, stuck, err, corrupt, exp_to, exp_ve, exp_se, exp_ops, exp_polls
  localparam int NV = 11;
  localparam int VEC [NV][10] = '{
    '{0, 1, 0, 0, 0, 0, 0, 0, 1, 1},
    '{0, 4, 0, 0, 0, 0, 0, 0, 1, 4},
    '{1, 1, 0, 0, 0, 0, 0, 0, 8, 8},
    '{1, 3, 0, 0, 0, 0, 0, 0, 8, 24},
    '{0, 2, 0, 0, 1, 0, 1, 0, 1, 2},
    '{1, 2, 0, 0, 1, 0, 1, 0, 8, 16},
    '{0, 1, 1, 0, 0, 1, 0, 0, 1, 6},
    '{1, 1, 1, 0, 0, 1, 1, 0, 1, 6},
    '{0, 1, 0, 1, 0, 0, 0, 1, 1, 1},
    '{1, 1, 0, 1, 0, 0, 1, 1, 1, 1},
    '{1, 6, 0, 0, 0, 0, 0, 0, 8, 48}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
  logic busy, done, timeout, stat_err, verify_err, fl_we, fl_re;
  logic [AW-1:0] fl_addr, buf_addr;
  logic [7:0] fl_wdata, fl_rdata, buf_data;

  flash_bank_seq #(.ADDR_W(AW), .POLL_LIMIT(PL), .SETUP_DLY(SD)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy), .done(done),
    .timeout(timeout), .stat_err(stat_err), .verify_err(verify_err),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata), .buf_addr(buf_addr), .buf_data(buf_data));

  always #10 clk = ~clk;

  logic [7:0] mem [NB];
  logic [7:0] bufm [NB];
  int nbusy = 1, polls = 0, cyc = 0, p_cyc = 0;
  bit stuck = 0, einj = 0, corr = 0, smode = 0, pend_e = 0, pend_p = 0, epi_ok = 0;
  logic [AW-1:0] p_addr = '0, prev_a = '0;
  logic [7:0] prev_d = 8'h00;
  int n_er = 0, n_pr = 0, n_st = 0, n_vr = 0, proto = 0;
  int errors = 0, checks = 0;

  assign buf_data = bufm[buf_addr];

  always @(posedge clk) begin
    cyc++;
    if (fl_we) begin
      if (pend_p) begin
        pend_p = 0;
        if (fl_addr == p_addr && cyc - p_cyc >= SD + 1) begin
          mem[fl_addr] = fl_wdata ^ {7'b0, corr && fl_addr == 2};
          n_pr++; polls = 0;
        end else proto++;
      end else if (pend_e) begin
        pend_e = 0;
        if (fl_addr == 0 && fl_wdata == 8'hD0) begin
          for (int i = 0; i < NB; i++) mem[i] = 8'hFF;
          if (corr) mem[2] = 8'hFE;
          n_er++; polls = 0;
        end else proto++;
      end else begin
        case (fl_wdata)
          8'h20: if (fl_addr == 0) pend_e = 1; else proto++;
          8'h40: begin pend_p = 1; p_addr = fl_addr; p_cyc = cyc; end
          8'h70: begin smode = 1; n_st++; if (fl_addr != 0) proto++; end
          8'h50: if (fl_addr != 0) proto++;
          8'hFF: begin
            smode = 0;
            if (fl_addr != 0) proto++;
            else if (prev_a == 0 && prev_d == 8'h50) epi_ok = 1;
          end
          default: proto++;
        endcase
      end
      prev_a = fl_addr; prev_d = fl_wdata;
    end
    if (fl_re) begin
      if (smode) begin
        polls++;
        fl_rdata <= (!stuck && polls >= nbusy) ? (einj ? 8'h90 : 8'h80) : 8'h00;
      end else begin
        n_vr++;
        fl_rdata <= mem[fl_addr];
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    n_er = 0; n_pr = 0; n_st = 0; n_vr = 0; proto = 0; epi_ok = 0;
    pend_e = 0; pend_p = 0; smode = 0; polls = 0;
  endtask

  task automatic wait_done();
    int w = 0;
    while (!done && w < 3000) begin @(negedge clk); w++; end
  endtask

  task automatic run_vec(int k);
    int md, bad;
    md = VEC[k][0];
    nbusy = VEC[k][1]; stuck = VEC[k][2] != 0; einj = VEC[k][3] != 0; corr = VEC[k][4] != 0;
    for (int i = 0; i < NB; i++) begin
      mem[i]  = md ? 8'hFF : 8'(i * 3);
      bufm[i] = 8'(i * 37 + k * 11 + 5);
    end
    clear_model();
    @(negedge clk); start = 1'b1; mode = md[0];
    @(negedge clk); start = 1'b0;
    check("R10 busy after start", int'(busy), 1);
    check("R10 flags cleared on start", int'({timeout, stat_err, verify_err}), 0);
    wait_done();
    check("R10 done pulse", int'(done), 1);
    check("R5 timeout flag", int'(timeout), VEC[k][5]);
    check("R6 status error flag", int'(stat_err), VEC[k][7]);
    check(md ? "R9 verify flag" : "R8 verify flag", int'(verify_err), VEC[k][6]);
    check(md ? "R4 program count" : "R2 erase count", md ? n_pr : n_er, VEC[k][8]);
    check(md ? "R4 no erase" : "R2 no program", md ? n_er : n_pr, 0);
    check("R3 status commands", n_st, VEC[k][9]);
    check("R2 R4 command protocol", proto, 0);
    check("R7 epilogue order", int'(epi_ok), 1);
    check(md ? "R9 readback count" : "R8 readback count", n_vr, NB);
    if (VEC[k][5] == 0 && VEC[k][7] == 0) begin
      bad = 0;
      for (int i = 0; i < NB; i++)
        if (mem[i] != (md ? bufm[i] ^ {7'b0, corr && i == 2} : (corr && i == 2 ? 8'hFE : 8'hFF))) bad++;
      check(md ? "R4 bank contents" : "R2 bank contents", bad, 0);
    end
    @(negedge clk);
    check("R10 done one cycle", int'(done), 0);
    check("R10 busy falls", int'(busy), 0);
    repeat (3) @(negedge clk);
    check("R10 flags hold", int'({timeout, stat_err, verify_err}),
          int'({VEC[k][5] != 0, VEC[k][7] != 0, VEC[k][6] != 0}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin mem[i] = 8'hFF; bufm[i] = 8'h00; end
    fl_rdata = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle flags", int'({timeout, stat_err, verify_err}), 0);
    check("R1 idle strobes", int'({fl_we, fl_re}), 0);

    for (int k = 0; k < NV; k++) run_vec(k);

    // R11: second start during a program job must not launch an erase
    nbusy = 1; stuck = 0; einj = 0; corr = 0;
    for (int i = 0; i < NB; i++) begin mem[i] = 8'hFF; bufm[i] = 8'(i + 100); end
    clear_model();
    @(negedge clk); start = 1'b1; mode = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; mode = 1'b0;
    @(negedge clk); start = 1'b0;
    wait_done();
    @(negedge clk);
    check("R11 no erase from busy start", n_er, 0);
    check("R11 program completed", n_pr, NB);
    check("R11 verify clean", int'(verify_err), 0);
    repeat (4) @(negedge clk);
    check("R11 stays idle", int'(busy), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule